// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Mode Controller

This block models the control side of a one-time-programmable word memory with a 17-bit word address and 16-bit words. Three active-low strobes (chip select, output gate and program pulse) together with two qualifier flags select what the memory does in a given cycle. One flag says the programming supply is raised. The other says that address bit 9 is held at the identification voltage. The block drives a 16-bit data bus with a separate drive-enable for the pad, reports the decoded mode, and raises an error flag for combinations that have no meaning.

The storage is a small behavioural register file of 2**STORE_W words, indexed by the low address bits. A program cycle can only clear bits: each write ANDs the input word into the stored word, so an unprogrammed word reads all ones. An access timer holds the drive-enable low until the controls and address have been steady for ACC_CYC clock edges, which stands in for the access time of the array.

The mode decode is combinational (`otpc_mode_dec`). The register file is `otpc_store`. The access timer is a three-state machine: ACC_IDLE, ACC_SETTLE and ACC_VALID (`otpc_access`). The timer moves ACC_IDLE→ACC_SETTLE on a driving request, ACC_SETTLE→ACC_VALID after ACC_CYC steady edges, and ACC_VALID or ACC_SETTLE→ACC_SETTLE when any watched input changes. It drops to ACC_IDLE from either state when the mode stops driving.

Top module: `otpc_top`

## Requirements
- R1: After reset every stored word reads 0xFFFF and `dout_en` is low.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hv`=0, `mode` is READ (2) and the word at the address is driven.
- R3: With `ce_n`=0 and `oe_n`=1, nothing is driven; `mode` is DISABLE (1), or PROGRAM (3) when the program condition of R5 holds.
- R4: With `ce_n`=1, nothing is driven and nothing is written; `mode` is INHIBIT (5) if `vpp_hi`=1, else STANDBY (0).
- R5: With `ce_n`=0, `oe_n`=1, `pgm_n`=0 and `vpp_hi`=1, `mode` is PROGRAM (3), and at each clock edge the addressed word becomes its old value AND `din`.
- R6: A program pulse without `vpp_hi` gives `mode` DISABLE (1) and leaves the stored word unchanged.
- R7: With `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=1 and `id_hv`=0, `mode` is VERIFY (4) and the addressed word is driven.
- R8: With `id_hv`=1, `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `addr[16:1]`=0, `mode` is IDENT (6) and the bus carries 0x001E when `addr[0]`=0 and 0x00F7 when `addr[0]`=1.
- R9: With `ce_n`=0 and `oe_n`=0, the mode is ILLEGAL (7) in two cases: `id_hv`=1 together with `vpp_hi`=1 or any of `addr[16:1]` set, and `vpp_hi`=1 with `pgm_n`=0. In ILLEGAL `err` is 1 and nothing is driven; in every other mode `err` is 0.
- R10: After any change of `addr`, `ce_n`, `oe_n`, `pgm_n`, `vpp_hi` or `id_hv`, `dout_en` falls at once and rises only after ACC_CYC clock edges with those inputs unchanged. `dout` is 0 whenever `dout_en` is low.
- R11: Words are selected by `addr[STORE_W-1:0]`, so addresses that differ only above that field reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets every word to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program pulse, active low |
| addr | input | 17 | Word address |
| din | input | 16 | Word to program |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Address bit 9 at identification voltage |
| dout | output | 16 | Data bus value (0 when not driven) |
| dout_en | output | 1 | Pad drive-enable for `dout` |
| mode | output | 3 | Decoded mode code (see R2 to R9) |
| err | output | 1 | Illegal qualifier combination |

## Verification
The bench builds the block with ACC_CYC=3 and STORE_W=4. An access window of three edges lets it see `dout_en` stay low after one and two steady edges and rise after the third. Sixteen words are few enough that random program and read sequences keep returning to the same words, so repeated AND-writes and address folding through bits 4 to 16 are both exercised.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_DISABLE = 3'd1,
        MODE_READ    = 3'd2,
        MODE_PROGRAM = 3'd3,
        MODE_VERIFY  = 3'd4,
        MODE_INHIBIT = 3'd5,
        MODE_IDENT   = 3'd6,
        MODE_ILLEGAL = 3'd7
    } otp_mode_e;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_SETTLE = 2'd1,
        ACC_VALID  = 2'd2
    } acc_state_e;

    localparam logic [15:0] ID_MAKER_WORD = 16'h001E;
    localparam logic [15:0] ID_PART_WORD  = 16'h00F7;

endpackage

// File: rtl/otpc_mode_dec.sv
module otpc_mode_dec
    import otpc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    output otp_mode_e         mode
);

    logic upper_clear;

    always_comb begin
        upper_clear = (addr[ADDR_W-1:1] == '0);
        mode        = MODE_STANDBY;
        unique case ({ce_n, oe_n})
            2'b10, 2'b11: begin
                mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
            end
            2'b01: begin
                mode = (vpp_hi && !pgm_n) ? MODE_PROGRAM : MODE_DISABLE;
            end
            2'b00: begin
                if (id_hv) begin
                    mode = (vpp_hi || !upper_clear) ? MODE_ILLEGAL : MODE_IDENT;
                end else if (vpp_hi) begin
                    mode = pgm_n ? MODE_VERIFY : MODE_ILLEGAL;
                end else begin
                    mode = MODE_READ;
                end
            end
            default: mode = MODE_STANDBY;
        endcase
    end

endmodule

// File: rtl/otpc_store.sv
module otpc_store #(
    parameter int DATA_W  = 16,
    parameter int STORE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [STORE_W-1:0] idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << STORE_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    assign rdata = cells[idx];

    // A word seen twice in a row at the same index never gains a set bit.
    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == $past(idx)) |-> ((rdata & ~$past(rdata)) == '0)); // R5

endmodule

// File: rtl/otpc_access.sv
module otpc_access
    import otpc_pkg::*;
#(
    parameter int KEY_W   = 22,
    parameter int ACC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    input  logic             drive_req,
    output logic             valid
);

    localparam int CNT_W = $clog2(ACC_CYC + 1) + 1;

    acc_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [KEY_W-1:0] key_q;
    logic             changed;
    logic             restart;

    assign changed = (key != key_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ACC_IDLE;
            cnt   <= '0;
            key_q <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            key_q <= key;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        restart = 1'b0;
        unique case (state)
            ACC_IDLE: begin
                if (drive_req) restart = 1'b1;
            end
            ACC_SETTLE: begin
                if (!drive_req) begin
                    state_n = ACC_IDLE;
                end else if (changed) begin
                    restart = 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                    if (int'(cnt) + 1 >= ACC_CYC) state_n = ACC_VALID;
                end
            end
            ACC_VALID: begin
                if (!drive_req) begin
                    state_n = ACC_IDLE;
                end else if (changed) begin
                    restart = 1'b1;
                end
            end
            default: state_n = ACC_IDLE;
        endcase
        if (restart) begin
            cnt_n   = CNT_W'(1);
            state_n = (ACC_CYC <= 1) ? ACC_VALID : ACC_SETTLE;
        end
        if (state_n == ACC_IDLE) cnt_n = '0;
    end

    always_comb begin
        valid = (state == ACC_VALID) && !changed && drive_req;
    end

    AST_KEY_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $stable(key)); // R10

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACC_VALID) |-> $past(drive_req)); // R10

endmodule

// File: rtl/otpc_top.sv
module otpc_top
    import otpc_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int STORE_W = 4,
    parameter int ACC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              vpp_hi,
    input  logic              id_hv,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [2:0]        mode,
    output logic              err
);

    localparam int KEY_W = ADDR_W + 5;

    otp_mode_e         cur_mode;
    logic [DATA_W-1:0] cell_word;
    logic [DATA_W-1:0] id_word;
    logic [DATA_W-1:0] bus_word;
    logic              drive_req;
    logic              wr_en;
    logic              settled;
    logic [KEY_W-1:0]  watch_key;

    otpc_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .addr   (addr),
        .mode   (cur_mode)
    );

    assign wr_en = (cur_mode == MODE_PROGRAM);

    otpc_store #(.DATA_W(DATA_W), .STORE_W(STORE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .idx   (addr[STORE_W-1:0]),
        .wdata (din),
        .rdata (cell_word)
    );

    assign watch_key = {addr, ce_n, oe_n, pgm_n, vpp_hi, id_hv};

    always_comb begin
        drive_req = (cur_mode == MODE_READ) || (cur_mode == MODE_VERIFY) ||
                    (cur_mode == MODE_IDENT);
        id_word   = addr[0] ? DATA_W'(ID_PART_WORD) : DATA_W'(ID_MAKER_WORD);
        bus_word  = (cur_mode == MODE_IDENT) ? id_word : cell_word;
    end

    otpc_access #(.KEY_W(KEY_W), .ACC_CYC(ACC_CYC)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .key       (watch_key),
        .drive_req (drive_req),
        .valid     (settled)
    );

    always_comb begin
        dout_en = settled;
        dout    = settled ? bus_word : '0;
        mode    = cur_mode;
        err     = (cur_mode == MODE_ILLEGAL);
    end

    AST_GATE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en); // R3

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en); // R4

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !dout_en); // R9

    AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && id_hv) |-> (dout == (addr[0] ? DATA_W'(16'h00F7) : DATA_W'(16'h001E)))); // R8

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R10

endmodule

// File: tb/otpc_top_bench.sv
module otpc_top_bench;

    localparam int ACC     = 3;
    localparam int SW      = 4;
    localparam int NWORDS  = 1 << SW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;
    logic [2:0]  mode;
    logic        err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] model [NWORDS];
    logic [21:0] prev_key = '0;
    bit          have_prev = 0;

    always #4 clk = ~clk;

    otpc_top #(.ADDR_W(17), .DATA_W(16), .STORE_W(SW), .ACC_CYC(ACC)) u_otpc_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .addr(addr), .din(din), .vpp_hi(vpp_hi), .id_hv(id_hv),
        .dout(dout), .dout_en(dout_en), .mode(mode), .err(err)
    );

    function automatic logic [2:0] exp_mode(logic c, logic o, logic p, logic v,
                                            logic h, logic [16:0] a);
        if (c) return v ? 3'd5 : 3'd0;                       // R4
        if (o) return (v && !p) ? 3'd3 : 3'd1;                // R3 R5 R6
        if (h) return (v || a[16:1] != 0) ? 3'd7 : 3'd6;      // R8 R9
        if (v) return p ? 3'd4 : 3'd7;                        // R7 R9
        return 3'd2;                                          // R2
    endfunction

    function automatic logic [15:0] exp_word(logic [2:0] m, logic [16:0] a);
        if (m == 3'd6) return a[0] ? 16'h00F7 : 16'h001E;
        return model[a[SW-1:0]];
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(logic c, logic o, logic p, logic v, logic h,
                         logic [16:0] a, logic [15:0] d, string req);
        logic [21:0] k;
        logic [2:0]  em;
        bit          drv, chg;
        @(negedge clk);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = h; addr = a; din = d;
        k   = {a, c, o, p, v, h};
        chg = !have_prev || (k != prev_key);
        prev_key  = k;
        have_prev = 1;
        em  = exp_mode(c, o, p, v, h, a);
        drv = (em == 3'd2) || (em == 3'd4) || (em == 3'd6);
        #1;
        chk(32'(mode), 32'(em), {req, " mode"});
        chk(32'(err), 32'(em == 3'd7), {req, " R9 err"});
        if (chg) begin
            chk(32'(dout_en), 0, "R10 enable drops on change");
            repeat (ACC - 1) @(negedge clk);
            #1;
            chk(32'(dout_en), 0, "R10 enable low before window");
            chk(32'(dout), 0, "R10 bus zero while idle");
        end
        @(negedge clk);
        #1;
        if (em == 3'd3) model[a[SW-1:0]] = model[a[SW-1:0]] & d;
        chk(32'(dout_en), 32'(drv), {req, " drive"});
        chk(32'(dout), drv ? 32'(exp_word(em, a)) : 0, {req, " data"});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NWORDS; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        #1;
        chk(32'(dout_en), 0, "R1 enable in reset");
        rst_n = 1'b1;
        // R1: all words erased
        for (int i = 0; i < NWORDS; i++) apply(0, 0, 1, 0, 0, 17'(i), 16'h0, "R1 erased");
        // R5 program and R2 read back, R7 verify
        apply(0, 1, 0, 1, 0, 17'd5, 16'h1234, "R5 program");
        apply(0, 0, 1, 0, 0, 17'd5, 16'h0, "R2 read");
        apply(0, 0, 1, 1, 0, 17'd5, 16'h0, "R7 verify");
        apply(0, 1, 0, 1, 0, 17'd5, 16'hFF00, "R5 second AND");
        apply(0, 0, 1, 0, 0, 17'd5, 16'h0, "R5 read after AND");
        // R6 program without supply
        apply(0, 1, 0, 0, 0, 17'd5, 16'h0000, "R6 no supply");
        apply(0, 0, 1, 0, 0, 17'd5, 16'h0, "R6 word kept");
        // R4 inhibit and standby
        apply(1, 1, 0, 1, 0, 17'd5, 16'h0000, "R4 inhibit");
        apply(1, 0, 0, 0, 0, 17'd5, 16'h0000, "R4 standby");
        apply(0, 0, 1, 0, 0, 17'd5, 16'h0, "R4 word kept");
        // R3 gate high
        apply(0, 1, 1, 0, 0, 17'd5, 16'h0, "R3 disable");
        // R8 ident
        apply(0, 0, 1, 0, 1, 17'd0, 16'h0, "R8 maker word");
        apply(0, 0, 1, 0, 1, 17'd1, 16'h0, "R8 part word");
        // R9 illegal
        apply(0, 0, 1, 0, 1, 17'h20, 16'h0, "R9 ident upper bit");
        apply(0, 0, 1, 1, 1, 17'd0, 16'h0, "R9 ident with supply");
        apply(0, 0, 0, 1, 0, 17'd3, 16'h0, "R9 pulse with gate low");
        // R11 folding
        apply(0, 1, 0, 1, 0, 17'h10, 16'h0F0F, "R11 program high alias");
        apply(0, 0, 1, 0, 0, 17'h00, 16'h0, "R11 read folded word");
        apply(0, 0, 1, 0, 0, 17'h1FFF0, 16'h0, "R11 read far alias");
        // R10 unchanged inputs keep driving
        apply(0, 0, 1, 0, 0, 17'h1FFF0, 16'h0, "R10 steady hold");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [16:0] ra;
            int          op;
            ra = 17'($urandom);
            if ($urandom_range(0, 1) == 0) ra = 17'($urandom_range(0, NWORDS - 1));
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1: apply(0, 1, 0, 1, 0, ra, 16'($urandom), "R5 rnd program");
                2, 3: apply(0, 0, 1, 0, 0, ra, 16'h0, "R2 rnd read");
                4:    apply(0, 0, 1, 1, 0, ra, 16'h0, "R7 rnd verify");
                5:    apply(0, 0, 1, 0, 1, {16'h0, ra[0]}, 16'h0, "R8 rnd ident");
                default: apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                               1'($urandom), ra, 16'($urandom), "R10 rnd mixed");
            endcase
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule